// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit turns the addressing fields of one instruction into the 16-bit address of its memory operand, for an 8-bit controller whose code and data share one 16-bit address space. It receives the mode, the one or two address bytes that follow the opcode, both index registers and the byte seen just before the opcode. That byte may be one of three prefix codes. One prefix swaps the index register. One turns the address byte into a zero-page pointer location. The third does both.

When no pointer fetch is needed, the address comes out combinationally and `done` rises in the same cycle as `req`. When a pointer must be fetched, the unit reads the zero page through a synchronous one-byte read port. Read data returns one cycle after the read is issued. `done` rises one cycle after the last read. The immediate mode yields no address; it raises `imm_op` instead. Using the immediate mode as a destination is flagged as an error.

Top module: `ea_gen`

## Requirements
- R1: Mode 1 (short absolute) gives ea = {8'h00, op_lo}. Mode 2 (long absolute) gives ea = {op_hi, op_lo}. Without a pointer fetch, `done` is high in the same cycle as `req`.
- R2: Mode 3 gives ea = index. Mode 4 gives ea = {8'h00, op_lo} + index as a full 16-bit sum, so it can reach 0x01FE. Mode 5 gives ea = {op_hi, op_lo} + index, truncated to 16 bits.
- R3: Prefix 0x90 selects `idx_y` in place of `idx_x` in modes 3, 4 and 5. It does not cause a memory read.
- R4: Any prefix byte other than 0x90, 0x91 and 0x92 behaves exactly as no prefix.
- R5: Mode 0 (immediate) raises `imm_op` and `done` in the request cycle, with ea = 0. `err` is 1 when `is_dest` is 1, and 0 otherwise. Other legal modes never set `err` for `is_dest`.
- R6: Prefix 0x92 with mode 1 or 4 issues one read at zero-page address op_lo. `done` is high one cycle later, with ea = data, plus the index for mode 4, as a full 16-bit sum.
- R7: Prefix 0x92 with mode 2 or 5 reads the high byte at op_lo and then the low byte at op_lo+1, in consecutive cycles. The second address wraps from 0xFF to 0x00. `done` is high one cycle after the second read. Mode 5 adds the index to the fetched address.
- R8: Prefix 0x91 performs the same pointer fetch as 0x92 and indexes with `idx_y`.
- R9: While a pointer fetch is in progress (`busy` high), `req` is ignored. It starts no read and produces no extra `done`.
- R10: In reset, and whenever idle with `req` low, `done`, `busy` and `rd_en` are 0. An asynchronous reset in the middle of a fetch clears `busy` and `rd_en` at once.
- R11: Modes 6 and 7 are reserved. They complete in the request cycle with `err` = 1, `imm_op` = 0 and ea = 0.
- R12: The indirect prefixes have no effect on modes 0 and 3. No read is issued, and the result is produced in the request cycle. Prefix 0x91 still selects `idx_y` in mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request for one address computation |
| mode | input | 3 | Addressing mode, 0..5 legal, 6..7 reserved |
| prefix | input | 8 | Byte preceding the opcode |
| op_hi | input | 8 | High address byte (long forms) |
| op_lo | input | 8 | Low address byte or pointer location |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| is_dest | input | 1 | Operand is written by the instruction |
| rd_en | output | 1 | Zero-page read strobe |
| rd_addr | output | 8 | Zero-page read address |
| rd_data | input | 8 | Read data, valid the cycle after rd_en |
| busy | output | 1 | Pointer fetch in progress |
| done | output | 1 | Result valid this cycle |
| ea | output | 16 | Effective address |
| imm_op | output | 1 | Operand is the immediate byte |
| err | output | 1 | Illegal mode or immediate destination |

## Verification
The assertions assume that the read port returns data exactly one cycle after `rd_en`. They also assume that `req` is meaningful only when sampled at a clock edge with inputs held stable across that edge. The bench's zero-page model responds one cycle after every strobe. Inputs change only on falling edges.

The checks on the second pointer address depend on the first read coming from the idle state. The stimulus starts every long fetch from idle, including the case where a second request is held high during the fetch.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

  typedef enum logic [2:0] {
    AM_IMM   = 3'd0,
    AM_DIR8  = 3'd1,
    AM_DIR16 = 3'd2,
    AM_IDX0  = 3'd3,
    AM_IDX8  = 3'd4,
    AM_IDX16 = 3'd5,
    AM_RSV6  = 3'd6,
    AM_RSV7  = 3'd7
  } amode_e;

  localparam logic [7:0] PFX_SWAP = 8'h90;
  localparam logic [7:0] PFX_BOTH = 8'h91;
  localparam logic [7:0] PFX_IND  = 8'h92;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_HI   = 2'd1,
    FS_LAST = 2'd2
  } fstate_e;

  typedef struct packed {
    logic use_y;
    logic indirect;
  } pfx_t;

endpackage

// File: rtl/ea_prefix_dec.sv
module ea_prefix_dec
  import ea_gen_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] prefix,
  output pfx_t          pfx
);

  always_comb begin
    pfx = '0;
    if (prefix == PFX_SWAP) begin
      pfx.use_y = 1'b1;
    end else if (prefix == PFX_BOTH) begin
      pfx.use_y    = 1'b1;
      pfx.indirect = 1'b1;
    end else if (prefix == PFX_IND) begin
      pfx.indirect = 1'b1;
    end
  end

endmodule

// File: rtl/ea_index_add.sv
module ea_index_add #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] idx,
  input  logic          add_en,
  output logic [AW-1:0] sum
);

  localparam int PADW = AW - DW;

  logic [AW-1:0] idx_ext;

  always_comb begin
    idx_ext = add_en ? {{PADW{1'b0}}, idx} : '0;
    sum     = base + idx_ext;
  end

endmodule

// File: rtl/ea_direct.sv
module ea_direct
  import ea_gen_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic [2:0]    mode,
  input  logic [DW-1:0] op_hi,
  input  logic [DW-1:0] op_lo,
  input  logic [DW-1:0] idx,
  output logic [AW-1:0] ea_dir,
  output logic          is_imm,
  output logic          is_rsv,
  output logic          ptr_mode,
  output logic          ptr_long,
  output logic          idx_used
);

  localparam int PADW = AW - DW;

  amode_e        am;
  logic [AW-1:0] base;

  always_comb begin
    am       = amode_e'(mode);
    base     = '0;
    is_imm   = 1'b0;
    is_rsv   = 1'b0;
    ptr_mode = 1'b0;
    ptr_long = 1'b0;
    idx_used = 1'b0;
    unique case (am)
      AM_IMM:   is_imm = 1'b1;
      AM_DIR8:  begin base = {{PADW{1'b0}}, op_lo}; ptr_mode = 1'b1; end
      AM_DIR16: begin base = {op_hi, op_lo}; ptr_mode = 1'b1; ptr_long = 1'b1; end
      AM_IDX0:  idx_used = 1'b1;
      AM_IDX8:  begin base = {{PADW{1'b0}}, op_lo}; ptr_mode = 1'b1; idx_used = 1'b1; end
      AM_IDX16: begin
        base     = {op_hi, op_lo};
        ptr_mode = 1'b1;
        ptr_long = 1'b1;
        idx_used = 1'b1;
      end
      AM_RSV6, AM_RSV7: is_rsv = 1'b1;
    endcase
  end

  ea_index_add #(.DW(DW), .AW(AW)) u_add (
    .base   (base),
    .idx    (idx),
    .add_en (idx_used),
    .sum    (ea_dir)
  );

endmodule

// File: rtl/ea_fetch_fsm.sv
module ea_fetch_fsm
  import ea_gen_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_long,
  input  logic [DW-1:0] ptr,
  input  logic [DW-1:0] idx_in,
  output logic          rd_en,
  output logic [DW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          fin,
  output logic [AW-1:0] fin_ea
);

  localparam int PADW = AW - DW;

  fstate_e       state_q, state_d;
  logic [DW-1:0] ptr_q, idx_q, hi_q;
  logic          long_q;
  logic          cap_en, hi_en;
  logic [AW-1:0] base;

  always_comb begin
    state_d = state_q;
    rd_en   = 1'b0;
    rd_addr = ptr;
    fin     = 1'b0;
    cap_en  = 1'b0;
    hi_en   = 1'b0;
    unique case (state_q)
      FS_IDLE: begin
        if (start) begin
          rd_en   = 1'b1;
          cap_en  = 1'b1;
          state_d = start_long ? FS_HI : FS_LAST;
        end
      end
      FS_HI: begin
        rd_en   = 1'b1;
        rd_addr = ptr_q + 1'b1;
        hi_en   = 1'b1;
        state_d = FS_LAST;
      end
      FS_LAST: begin
        fin     = 1'b1;
        state_d = FS_IDLE;
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      ptr_q   <= '0;
      idx_q   <= '0;
      long_q  <= 1'b0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        ptr_q  <= ptr;
        idx_q  <= idx_in;
        long_q <= start_long;
      end
      if (hi_en) begin
        hi_q <= rd_data;
      end
    end
  end

  assign busy = (state_q != FS_IDLE);
  assign base = long_q ? {hi_q, rd_data} : {{PADW{1'b0}}, rd_data};

  ea_index_add #(.DW(DW), .AW(AW)) u_add (
    .base   (base),
    .idx    (idx_q),
    .add_en (1'b1),
    .sum    (fin_ea)
  );

  AST_HI_ADDR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_HI) |-> (rd_addr == DW'($past(rd_addr) + 1'b1))); // R7
  AST_LAST_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_LAST) |-> !rd_en); // R9
  AST_HI_NOT_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_HI) |=> fin); // R7

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [2:0]    mode,
  input  logic [DW-1:0] prefix,
  input  logic [DW-1:0] op_hi,
  input  logic [DW-1:0] op_lo,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic          is_dest,
  output logic          rd_en,
  output logic [DW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done,
  output logic [2*DW-1:0] ea,
  output logic          imm_op,
  output logic          err
);

  localparam int AW = 2 * DW;

  pfx_t          pfx;
  logic [DW-1:0] idx_sel, idx_fetch;
  logic [AW-1:0] ea_dir, fin_ea;
  logic          is_imm, is_rsv, ptr_mode, ptr_long, idx_used;
  logic          acc, need_fetch, start, quick, fin;

  ea_prefix_dec #(.DW(DW)) u_pfx (
    .prefix (prefix),
    .pfx    (pfx)
  );

  assign idx_sel = pfx.use_y ? idx_y : idx_x;

  ea_direct #(.DW(DW), .AW(AW)) u_dir (
    .mode     (mode),
    .op_hi    (op_hi),
    .op_lo    (op_lo),
    .idx      (idx_sel),
    .ea_dir   (ea_dir),
    .is_imm   (is_imm),
    .is_rsv   (is_rsv),
    .ptr_mode (ptr_mode),
    .ptr_long (ptr_long),
    .idx_used (idx_used)
  );

  always_comb begin
    acc        = req & ~busy;
    need_fetch = pfx.indirect & ptr_mode;
    start      = acc & need_fetch;
    quick      = acc & ~need_fetch;
    idx_fetch  = idx_used ? idx_sel : '0;
  end

  ea_fetch_fsm #(.DW(DW), .AW(AW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_long (ptr_long),
    .ptr        (op_lo),
    .idx_in     (idx_fetch),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .busy       (busy),
    .fin        (fin),
    .fin_ea     (fin_ea)
  );

  always_comb begin
    done   = quick | fin;
    ea     = fin ? fin_ea : (quick ? ea_dir : '0);
    imm_op = quick & is_imm;
    err    = quick & (is_rsv | (is_imm & is_dest));
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !busy) |-> (!done && !rd_en)); // R10
  AST_READ_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy) |=> busy); // R6
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done)); // R7
  AST_IMM_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    imm_op |-> (!rd_en && !busy)); // R12

endmodule

// File: tb/tb_ea_gen.sv
`timescale 1ns/1ps
module tb_ea_gen;

  logic       clk, rst_n, req, is_dest;
  logic [2:0] mode;
  logic [7:0] prefix, op_hi, op_lo, idx_x, idx_y, rd_addr, rd_data;
  logic       rd_en, busy, done, imm_op, err;
  logic [15:0] ea;

  int n_chk = 0, n_bad = 0, rd_cnt = 0;
  bit finished = 0;

  ea_gen #(.DW(8)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .prefix(prefix),
    .op_hi(op_hi), .op_lo(op_lo), .idx_x(idx_x), .idx_y(idx_y),
    .is_dest(is_dest), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .ea(ea), .imm_op(imm_op), .err(err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [7:0] a);
    return 8'(a * 8'd7 + 8'd3);
  endfunction

  always @(posedge clk) begin
    if (rd_en) rd_data <= mem_f(rd_addr);
    if (rst_n && rd_en) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input bit ok, input string what, input int rq,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  typedef struct packed {
    logic [2:0]  md;
    logic [7:0]  pf, hi, lo, x, y;
    logic        dst;
    logic [15:0] ea;
    logic        imm, er;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 8'h00, 8'h12, 8'h34, 8'h00, 8'h00, 1'b0, 16'h0034, 1'b0, 1'b0, 4'd1},  // R1
    '{3'd2, 8'h00, 8'h12, 8'h34, 8'h00, 8'h00, 1'b0, 16'h1234, 1'b0, 1'b0, 4'd1},  // R1
    '{3'd3, 8'h00, 8'h00, 8'h00, 8'h56, 8'h9A, 1'b0, 16'h0056, 1'b0, 1'b0, 4'd2},  // R2
    '{3'd4, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00, 1'b0, 16'h01FE, 1'b0, 1'b0, 4'd2},  // R2
    '{3'd5, 8'h00, 8'hFF, 8'hF0, 8'h20, 8'h00, 1'b0, 16'h0010, 1'b0, 1'b0, 4'd2},  // R2
    '{3'd4, 8'h90, 8'h00, 8'h10, 8'h01, 8'h05, 1'b0, 16'h0015, 1'b0, 1'b0, 4'd3},  // R3
    '{3'd5, 8'h90, 8'h20, 8'h00, 8'h01, 8'h80, 1'b0, 16'h2080, 1'b0, 1'b0, 4'd3},  // R3
    '{3'd3, 8'h90, 8'h00, 8'h00, 8'h56, 8'h9A, 1'b0, 16'h009A, 1'b0, 1'b0, 4'd3},  // R3
    '{3'd4, 8'h93, 8'h00, 8'h10, 8'h01, 8'h05, 1'b0, 16'h0011, 1'b0, 1'b0, 4'd4},  // R4
    '{3'd5, 8'h8F, 8'h01, 8'h00, 8'h02, 8'h07, 1'b0, 16'h0102, 1'b0, 1'b0, 4'd4},  // R4
    '{3'd0, 8'h00, 8'h12, 8'h34, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd5},  // R5
    '{3'd0, 8'h00, 8'h12, 8'h34, 8'h00, 8'h00, 1'b1, 16'h0000, 1'b1, 1'b1, 4'd5},  // R5
    '{3'd1, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00, 1'b1, 16'h0080, 1'b0, 1'b0, 4'd5},  // R5
    '{3'd6, 8'h00, 8'h12, 8'h34, 8'h01, 8'h01, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd11}, // R11
    '{3'd7, 8'h92, 8'h12, 8'h34, 8'h01, 8'h01, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd11}, // R11
    '{3'd0, 8'h92, 8'h00, 8'h40, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd12}, // R12
    '{3'd3, 8'h91, 8'h00, 8'h40, 8'h44, 8'h33, 1'b0, 16'h0033, 1'b0, 1'b0, 4'd12}, // R12
    '{3'd3, 8'h92, 8'h00, 8'h40, 8'h44, 8'h33, 1'b0, 16'h0044, 1'b0, 1'b0, 4'd12}  // R12
  };

  task automatic do_op(input logic [2:0] md, input logic [7:0] pf, hi, lo, x, y,
                       input logic dst, input logic [15:0] exp_ea,
                       input logic exp_imm, exp_err, input int exp_lat,
                       input int exp_rd, input int rq);
    int got, r0;
    logic [15:0] g_ea;
    logic g_imm, g_err;
    got = -1; g_ea = '0; g_imm = 0; g_err = 0;
    @(negedge clk);
    r0 = rd_cnt;
    mode = md; prefix = pf; op_hi = hi; op_lo = lo;
    idx_x = x; idx_y = y; is_dest = dst; req = 1'b1;
    for (int c = 0; c < 4; c++) begin
      #1;
      if (done && got < 0) begin
        got = c; g_ea = ea; g_imm = imm_op; g_err = err;
      end
      @(negedge clk);
      req = 1'b0;
    end
    chk(got == exp_lat, "done cycle", rq, got, exp_lat);
    chk(g_ea == exp_ea, "ea", rq, g_ea, exp_ea);
    chk(g_imm == exp_imm, "imm_op", rq, g_imm, exp_imm);
    chk(g_err == exp_err, "err", rq, g_err, exp_err);
    chk((rd_cnt - r0) == exp_rd, "read count", rq, rd_cnt - r0, exp_rd);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int r0, dcnt;
    logic [15:0] sea;
    rst_n = 1'b0; req = 1'b0; mode = '0; prefix = '0; op_hi = '0; op_lo = '0;
    idx_x = '0; idx_y = '0; is_dest = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R10 outputs quiet in reset
    chk(!done && !busy && !rd_en, "quiet in reset", 10, {done, busy, rd_en}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!done && !busy && !rd_en, "quiet after reset", 10, {done, busy, rd_en}, 0);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i].md, VEC[i].pf, VEC[i].hi, VEC[i].lo, VEC[i].x, VEC[i].y,
            VEC[i].dst, VEC[i].ea, VEC[i].imm, VEC[i].er, 0, 0, int'(VEC[i].rq));
    end

    // R6 short pointer, plain and indexed (full-width sum)
    do_op(3'd1, 8'h92, 8'hAA, 8'h10, 8'h00, 8'h00, 1'b0, 16'h0073, 0, 0, 1, 1, 6);
    do_op(3'd4, 8'h92, 8'hAA, 8'h20, 8'hF0, 8'h00, 1'b0, 16'h01D3, 0, 0, 1, 1, 6);
    // R7 long pointer, high byte first, with zero-page wrap and indexing
    do_op(3'd2, 8'h92, 8'hAA, 8'h40, 8'h00, 8'h00, 1'b0, 16'hC3CA, 0, 0, 2, 2, 7);
    do_op(3'd2, 8'h92, 8'hAA, 8'hFF, 8'h00, 8'h00, 1'b0, 16'hFC03, 0, 0, 2, 2, 7);
    do_op(3'd5, 8'h92, 8'hAA, 8'h40, 8'h50, 8'h00, 1'b0, 16'hC41A, 0, 0, 2, 2, 7);
    // R8 pointer fetch indexed by Y
    do_op(3'd4, 8'h91, 8'hAA, 8'h10, 8'h01, 8'h22, 1'b0, 16'h0095, 0, 0, 1, 1, 8);
    do_op(3'd5, 8'h91, 8'hAA, 8'hFF, 8'h01, 8'hFF, 1'b0, 16'hFD02, 0, 0, 2, 2, 8);

    // R9 request held during a long fetch is ignored
    @(negedge clk);
    r0 = rd_cnt; dcnt = 0; sea = '0;
    mode = 3'd2; prefix = 8'h92; op_lo = 8'h40; req = 1'b1;
    #1;
    if (done) dcnt++;
    @(negedge clk);
    mode = 3'd1; prefix = 8'h00; op_lo = 8'h55;
    #1;
    chk(!done, "no done for request while busy", 9, done, 0);
    @(negedge clk); #1;
    if (done) begin dcnt++; sea = ea; end
    @(negedge clk);
    req = 1'b0;
    #1;
    if (done) dcnt++;
    @(negedge clk);
    chk(dcnt == 1, "done pulses", 9, dcnt, 1);
    chk(sea == 16'hC3CA, "fetched ea kept", 9, sea, 16'hC3CA);
    chk((rd_cnt - r0) == 2, "reads while busy", 9, rd_cnt - r0, 2);

    // R10 asynchronous reset during a fetch
    @(negedge clk);
    mode = 3'd2; prefix = 8'h92; op_lo = 8'h40; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    #1;
    rst_n = 1'b0;
    #0.5;
    chk(!busy && !rd_en, "reset mid-fetch", 10, {busy, rd_en}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!done && !busy, "idle after mid-fetch reset", 10, {done, busy}, 0);

    // R1 normal operation resumes after reset
    do_op(3'd2, 8'h00, 8'hBE, 8'hEF, 8'h00, 8'h00, 1'b0, 16'hBEEF, 0, 0, 0, 0, 1);
    finish_run();
  end

endmodule